// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

A target on an I2C bus that loses track partway through a byte can keep SDA pulled low, and this stalls every later transfer. This block frees the bus. On a start request it takes over the two open-drain pads from the normal I2C controller and releases both lines first. It then clocks SCL a fixed number of times so that the target can shift out whatever it still holds. Before each pulse it waits for SCL to read high, so a target that stretches the clock is never overrun.

After the pulses the block drives a closing edge pattern. SDA goes low while SCL is high, then SCL goes low, then SCL is released, and SDA is released last. Releasing SDA while SCL is high forms a STOP. The block then returns the pads to the controller and raises a one-cycle done pulse. Every delay is one step of `STEP_US` microseconds. The step is built from a prescaled microsecond tick of `CLKS_PER_US` clocks, so one step lasts S = CLKS_PER_US × STEP_US clocks. The block does not check that SDA really came free, and it does not arbitrate against other masters.

Top module: `i2c_bus_recover`

## Requirements
- R1: After reset, and whenever no sequence runs, busy, pad ownership, done and both output enables are 0.
- R2: A start request sampled high while idle sets busy and pad ownership in the next cycle. In that cycle both pads are released.
- R3: Exactly `PULSES` (default 8) SCL low pulses are produced with SDA released, and SDA is not pulled until all of them are done.
- R4: Each pulse pulls SCL low for exactly S clocks and then releases it for S clocks.
- R5: Before each pulse the block samples scl_i. If scl_i is low, it rechecks once every S clocks. A pulse starts only in the cycle after scl_i was sampled high. With no stretching, the released phase between pulses lasts S+1 clocks. If SCL is held low for H clocks from the start of a released phase, that phase lasts S + k·S + 1 clocks, where k is the smallest integer ≥ 0 with S + k·S ≥ H.
- R6: After the last pulse's released phase, the closing pattern runs in this order:
  - SDA pulled with SCL released for S clocks.
  - Both lines pulled for S clocks.
  - SDA pulled with SCL released for S clocks.
  - SDA released.
- R7: done is high for exactly one cycle. That cycle is the first one with busy and ownership low. Without stretching, busy lasts PULSES·(2S+1) + 3S clocks.
- R8: A start request while busy has no effect: the sequence of pad states and its length are unchanged.
- R9: An output enable of 1 pulls its pad low. An output enable of 0 releases the pad, so the line reads high unless another device holds it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to run one recovery sequence |
| scl_i | input | 1 | Sampled level of the SCL line |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| pad_own_o | output | 1 | 1 while this block owns the pads, 0 hands them to the controller |
| busy_o | output | 1 | High for the whole sequence |
| done_o | output | 1 | One-cycle pulse when the pads are returned |

## Verification
Busy and ownership appear one clock after the edge that samples start_i. After that, every pad state lasts a whole number of steps of S clocks, except for the one-clock probe before each pulse. The bench therefore computes the expected length of every run of constant output enables arithmetically: 1, then alternating S and S+1, with S + k·S + 1 for a stretched gap, then three runs of S. It measures the runs by sampling the outputs on the falling clock edge and compares each run to its expected value. The bench holds SCL low for a swept number of clocks starting in the first released cycle, and expects done in the first cycle after the last run.

// File: rtl/bus_recover_pkg.sv
package bus_recover_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROBE,
    ST_PULSE_LO,
    ST_PULSE_HI,
    ST_DATA_LO,
    ST_CLK_LO,
    ST_CLK_HI
  } rec_state_e;

  // clocks in one delay step
  function automatic int unsigned step_clks(int unsigned clks_per_us, int unsigned step_us);
    return clks_per_us * step_us;
  endfunction

  // clocks of a full unstretched sequence
  function automatic int unsigned seq_clks(int unsigned pulses, int unsigned step);
    return pulses * (2 * step + 1) + 3 * step;
  endfunction

endpackage

// File: rtl/rec_us_tick.sv
module rec_us_tick #(
  parameter int unsigned CLKS_PER_US = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CNT_W = $clog2(CLKS_PER_US + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CLKS_PER_US - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX); // R4

endmodule

// File: rtl/rec_step_timer.sv
module rec_step_timer #(
  parameter int unsigned STEP_US = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic tick_i,
  output logic step_done_o
);
  localparam int US_W = $clog2(STEP_US + 1);
  localparam logic [US_W-1:0] US_MAX = US_W'(STEP_US - 1);

  logic [US_W-1:0] us_q;

  assign step_done_o = tick_i && (us_q == US_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           us_q <= '0;
    else if (clr_i)       us_q <= '0;
    else if (step_done_o) us_q <= '0;
    else if (tick_i)      us_q <= us_q + 1'b1;
  end

  AST_STEP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (us_q != $past(us_q) && !$past(clr_i)) |-> $past(tick_i)); // R4

endmodule

// File: rtl/rec_sequencer.sv
module rec_sequencer
  import bus_recover_pkg::*;
#(
  parameter int unsigned PULSES = 8,
  parameter int unsigned STEP   = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic scl_i,
  input  logic step_done_i,
  output logic timer_clr_o,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic pad_own_o,
  output logic busy_o,
  output logic done_o
);
  localparam int PCNT_W = $clog2(PULSES + 1);
  localparam int RUN_W  = $clog2(STEP + 2);

  rec_state_e        state_q, state_d;
  logic [PCNT_W-1:0] pulse_q;
  logic              probe_q;
  logic              done_q;

  // named events
  logic start_accept, pulse_end, seq_exit, last_pulse;
  assign start_accept = (state_q == ST_IDLE) && start_i;
  assign pulse_end    = (state_q == ST_PULSE_HI) && step_done_i;
  assign seq_exit     = (state_q == ST_CLK_HI) && step_done_i;
  assign last_pulse   = (pulse_q == PCNT_W'(PULSES - 1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (start_i)          state_d = ST_PROBE;
      ST_PROBE:    if (probe_q && scl_i) state_d = ST_PULSE_LO;
      ST_PULSE_LO: if (step_done_i)      state_d = ST_PULSE_HI;
      ST_PULSE_HI: if (step_done_i)      state_d = last_pulse ? ST_DATA_LO : ST_PROBE;
      ST_DATA_LO:  if (step_done_i)      state_d = ST_CLK_LO;
      ST_CLK_LO:   if (step_done_i)      state_d = ST_CLK_HI;
      ST_CLK_HI:   if (step_done_i)      state_d = ST_IDLE;
      default:                           state_d = ST_IDLE;
    endcase
  end

  // timer restarts on every state change and stays cleared while idle
  assign timer_clr_o = (state_d != state_q) || (state_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pulse_q <= '0;
      probe_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      probe_q <= (state_d == ST_PROBE) && ((state_q != ST_PROBE) || step_done_i);
      done_q  <= seq_exit;
      if (start_accept)   pulse_q <= '0;
      else if (pulse_end) pulse_q <= pulse_q + 1'b1;
    end
  end

  assign scl_oe_o  = (state_q == ST_PULSE_LO) || (state_q == ST_CLK_LO);
  assign sda_oe_o  = (state_q == ST_DATA_LO) || (state_q == ST_CLK_LO) || (state_q == ST_CLK_HI);
  assign busy_o    = (state_q != ST_IDLE);
  assign pad_own_o = busy_o;
  assign done_o    = done_q;

  // length of the current SCL-low run, used only by the checks
  logic [RUN_W-1:0] low_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_run_q <= '0;
    else if (scl_oe_o) low_run_q <= low_run_q + 1'b1;
    else               low_run_q <= '0;
  end

  AST_LOW_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    low_run_q <= RUN_W'(STEP)); // R4
  AST_PULSE_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(scl_oe_o) && !sda_oe_o) |-> $past(scl_i)); // R5
  AST_SDA_AFTER_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> (pulse_q == PCNT_W'(PULSES))); // R3
  AST_STOP_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe_o) |-> (!scl_oe_o && !$past(scl_oe_o))); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!pad_own_o && !scl_oe_o && !sda_oe_o && $past(busy_o))); // R7
  AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (pulse_q >= $past(pulse_q))); // R8

endmodule

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover
  import bus_recover_pkg::*;
#(
  parameter int unsigned CLKS_PER_US = 125,
  parameter int unsigned STEP_US     = 10,
  parameter int unsigned PULSES      = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic scl_i,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic pad_own_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned STEP = step_clks(CLKS_PER_US, STEP_US);

  logic timer_clr, us_tick, step_done;

  rec_us_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (timer_clr),
    .tick_o (us_tick)
  );

  rec_step_timer #(.STEP_US(STEP_US)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (timer_clr),
    .tick_i      (us_tick),
    .step_done_o (step_done)
  );

  rec_sequencer #(.PULSES(PULSES), .STEP(STEP)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .scl_i       (scl_i),
    .step_done_i (step_done),
    .timer_clr_o (timer_clr),
    .scl_oe_o    (scl_oe_o),
    .sda_oe_o    (sda_oe_o),
    .pad_own_o   (pad_own_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

endmodule

// File: tb/i2c_bus_recover_test.sv
module i2c_bus_recover_test;
  localparam int CPU = 2;
  localparam int SUS = 3;
  localparam int NP  = 8;
  localparam int S   = SUS * CPU;
  localparam int NRUNS = 2 * NP + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic ext_low = 1'b0;
  logic scl_oe, sda_oe, own, busy, done;
  wire  scl_i = !(scl_oe | ext_low);   // R9: oe=1 pulls low

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  i2c_bus_recover #(.CLKS_PER_US(CPU), .STEP_US(SUS), .PULSES(NP)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .scl_i(scl_i),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .pad_own_o(own),
    .busy_o(busy), .done_o(done)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle_check(string tag);
    chk(!busy && !own && !done, "R1", {tag, " status"}, {busy, own, done}, 0);
    chk(!scl_oe && !sda_oe, "R1", {tag, " pads"}, {scl_oe, sda_oe}, 0);
  endtask

  // run one sequence; SCL held low for h clocks after pulse 2
  task automatic run_seq(int h, bit mid);
    int exp_c[NRUNS];
    int exp_l[NRUNS];
    int k = 0, len = 0, cur = 0, busy_n = 0, left = 0, viol = 0, extra = 0, c = 0, total = 0;
    bit prev_scl;
    string req;
    if (h > S) extra = ((h - S + S - 1) / S) * S;
    exp_c[0] = 0; exp_l[0] = 1;
    for (int p = 1; p <= NP; p++) begin
      exp_c[2*p-1] = 2; exp_l[2*p-1] = S;
      exp_c[2*p]   = 0; exp_l[2*p]   = (p < NP) ? S + 1 : S;
      if (p == 2) exp_l[2*p] += extra;
    end
    exp_c[2*NP+1] = 1; exp_l[2*NP+1] = S;
    exp_c[2*NP+2] = 3; exp_l[2*NP+2] = S;
    exp_c[2*NP+3] = 1; exp_l[2*NP+3] = S;
    for (int i = 0; i < NRUNS; i++) total += exp_l[i];

    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk(busy && own, "R2", "busy/own after start", {busy, own}, 3);
    chk(!scl_oe && !sda_oe, "R2", "pads released at start", {scl_oe, sda_oe}, 0);
    cur = {scl_oe, sda_oe}; len = 1; busy_n = 1;
    prev_scl = !(scl_oe | ext_low);
    for (int cyc = 0; cyc < 5000; cyc++) begin
      @(negedge clk);
      if (left > 0) begin left--; if (left == 0) ext_low = 1'b0; end
      start_i = mid && (k == 9) && (len == 2);   // R8 stimulus
      if (!busy) break;
      busy_n++;
      c = {scl_oe, sda_oe};
      if (c == 2 && cur != 2 && !prev_scl) viol++;
      if (c == cur) len++;
      else begin
        req = (cur == 2) ? "R4" : (cur == 0) ? ((k == 4) ? "R5" : "R4") : "R6";
        if (k < NRUNS) begin
          chk(cur == exp_c[k], req, $sformatf("run %0d pads", k), cur, exp_c[k]);
          chk(len == exp_l[k], req, $sformatf("run %0d length h=%0d", k, h), len, exp_l[k]);
        end
        k++;
        if (cur == 2 && c == 0 && k == 4 && h > 0) begin ext_low = 1'b1; left = h; end
        cur = c; len = 1;
      end
      prev_scl = !(scl_oe | ext_low);
    end
    start_i = 1'b0;
    if (k < NRUNS) begin
      chk(cur == exp_c[k], "R6", "last run pads", cur, exp_c[k]);
      chk(len == exp_l[k], "R6", "last run length", len, exp_l[k]);
    end
    chk(k + 1 == NRUNS, "R3", "run count", k + 1, NRUNS);
    chk(viol == 0, "R5", "pulse began with SCL low", viol, 0);
    chk(busy_n == total, "R7", $sformatf("busy cycles h=%0d", h), busy_n, total);
    if (h == 0)
      chk(busy_n == NP * (2 * S + 1) + 3 * S, "R7", "unstretched length", busy_n, NP * (2 * S + 1) + 3 * S);
    chk(done && !own && !scl_oe && !sda_oe, "R7", "done with pads returned", {done, own, scl_oe, sda_oe}, 8);
    @(negedge clk);
    chk(!done, "R7", "done one cycle", done, 0);
    idle_check("after sequence");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    idle_check("in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    idle_check("after reset");
    for (int h = 0; h <= 2 * S + 2; h++) run_seq(h, h[0]);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule